// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It stores 32-bit trace words from a valid/data input into an on-chip RAM that is used as a ring. Software reaches the block through a simple register bus. Through that bus it sets the fill and drain pointers, and it writes or reads the RAM through two data ports that step their pointer after each access. A control bit starts and stops capture. A status flag reports that the fill pointer has wrapped, so the oldest data then starts at the fill pointer.

Capture can end cleanly in two ways. The first is a trigger: capture runs on for a programmed number of words after it. The second is a manual flush request, which clears itself when it is done. In both cases the block writes zero words until the fill pointer sits on a 4-word frame boundary. A formatter status bit reports when capture has come to rest.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, capture is off. Register 0x020 reads 0, register 0x300 reads 0x2 (bit 1 = stopped), register 0x00C reads 0, both pointers (0x014, 0x018) read 0, the trigger counter (0x01C) reads 0, and register 0x004 reads DEPTH.
- R2: While capture is off, a write to 0x024 stores the word at the fill pointer and then adds one to that pointer. While capture is on, such a write is ignored.
- R3: A read of 0x010 returns the word at the drain pointer and then adds one to that pointer. The drain pointer wraps from DEPTH-1 to 0.
- R4: Bit 0 of 0x00C sets when a store moves the fill pointer from DEPTH-1 to 0. A write to 0x018 while capture is off loads the fill pointer and clears that bit.
- R5: Writing 1 to bit 0 of 0x020 starts capture. Each cycle with trc_valid then stores trc_data. Writing 0 stops capture at the next edge, after which 0x300 bit 1 reads 1. Trace words that arrive while capture is stopped are not stored.
- R6: With 0x304 bit 13 set, a trc_trigger pulse arms the trigger stop. The word in the trigger cycle and every later stored word each take one from 0x01C. When that counter reaches zero, capture ends.
- R7: If 0x01C is already zero when an armed trigger arrives, the word in that cycle is not stored and the stop starts at once.
- R8: With 0x304 bit 13 clear, trc_trigger has no effect: capture goes on and 0x01C keeps its value.
- R9: A trigger stop writes zero words, one per cycle, until the fill pointer is a multiple of 4. Capture then ends and 0x020 reads 0.
- R10: Writing 1 to 0x304 bit 6 during capture starts a flush. Bit 6 reads 1 while the flush pads to a frame boundary and clears when the flush is done. Capture then ends if bit 12 is set and goes on if bit 12 is clear. Bits 0, 12 and 13 of 0x304 read back as written.
- R11: A flush request made while capture is off completes at once, so 0x304 bit 6 reads 0.
- R12: A trace word presented in the same cycle as a flush request is stored before the padding starts.
- R13: While capture is on, writes to 0x018 and 0x01C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| trc_valid | input | 1 | Trace word present |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger pulse |

## Verification
Two pairs of events can fall in the same cycle and need a rule to decide between them. The first pair is a trigger pulse and a valid trace word. The word must be stored and must count as the first post-trigger word, unless the counter is already zero, in which case it is dropped. The second pair is a flush request on the bus and a valid trace word. The word must land before the zero padding starts. The bench drives both members of each pair in the same cycle. It judges the result by the final fill pointer and by reading the RAM back through the read-data port.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int FRAME_LOG = 2;

    localparam logic [ADDR_W-1:0] A_DEPTH  = 12'h004;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h00C;
    localparam logic [ADDR_W-1:0] A_RDATA  = 12'h010;
    localparam logic [ADDR_W-1:0] A_RPTR   = 12'h014;
    localparam logic [ADDR_W-1:0] A_WPTR   = 12'h018;
    localparam logic [ADDR_W-1:0] A_TCNT   = 12'h01C;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h020;
    localparam logic [ADDR_W-1:0] A_WDATA  = 12'h024;
    localparam logic [ADDR_W-1:0] A_FSTAT  = 12'h300;
    localparam logic [ADDR_W-1:0] A_FCTRL  = 12'h304;

    localparam int FC_EN      = 0;
    localparam int FC_FLUSH   = 6;
    localparam int FC_STOPFL  = 12;
    localparam int FC_STOPTRG = 13;
    localparam int FS_STOPPED = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAPT  = 2'd1,
        ST_PAD   = 2'd2,
        ST_FLUSH = 2'd3
    } seq_state_e;
endpackage

// File: rtl/trace_ring_ram.sv
module trace_ring_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trace_ring_seq.sv
module trace_ring_seq
    import trace_ring_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_on_wr,
    input  logic             cap_off_wr,
    input  logic             flush_req,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             stop_trig_en,
    input  logic             stop_flush_en,
    input  logic             trc_valid,
    input  logic             trc_trigger,
    input  logic             wp_aligned,
    output logic             capturing,
    output logic             stopped,
    output logic             flush_busy,
    output logic             store_trace,
    output logic             store_pad,
    output logic [CNT_W-1:0] cnt_val
);
    typedef struct packed {
        seq_state_e       st;
        logic             seen;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic trig_act;

    always_comb begin
        s_d         = s_q;
        store_trace = 1'b0;
        store_pad   = 1'b0;
        trig_act    = stop_trig_en & (trc_trigger | s_q.seen);
        unique case (s_q.st)
            ST_IDLE: begin
                if (cap_on_wr) begin
                    s_d.st   = ST_CAPT;
                    s_d.seen = 1'b0;
                end
                if (cnt_wr) begin
                    s_d.cnt = cnt_wdata;
                end
            end
            ST_CAPT: begin
                s_d.seen = s_q.seen | (stop_trig_en & trc_trigger);
                if (trig_act && s_q.cnt == '0) begin
                    s_d.st = ST_PAD;
                end else begin
                    store_trace = trc_valid;
                    if (trc_valid && trig_act) begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                        if (s_q.cnt == CNT_W'(1)) begin
                            s_d.st = ST_PAD;
                        end
                    end
                    if (s_d.st == ST_CAPT && flush_req) begin
                        s_d.st = ST_FLUSH;
                    end
                end
            end
            ST_PAD: begin
                store_pad = ~wp_aligned;
                if (wp_aligned) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: begin
                store_pad = ~wp_aligned;
                if (wp_aligned) begin
                    s_d.st = stop_flush_en ? ST_IDLE : ST_CAPT;
                end
            end
        endcase
        if (cap_off_wr) begin
            s_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, seen: 1'b0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign capturing  = (s_q.st != ST_IDLE);
    assign stopped    = (s_q.st == ST_IDLE);
    assign flush_busy = (s_q.st == ST_FLUSH);
    assign cnt_val    = s_q.cnt;
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              trc_valid,
    input  logic [WORD_W-1:0] trc_data,
    input  logic              trc_trigger
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic             full;
        logic             fmt_en;
        logic             stop_flush;
        logic             stop_trig;
    } regs_t;

    regs_t regs_d, regs_q;

    logic wr_hit, rd_hit;
    logic cap_on_wr, cap_off_wr, flush_req, cnt_wr;
    logic capturing, stopped, flush_busy, store_trace, store_pad;
    logic port_store, ram_we, wp_aligned;
    logic [WORD_W-1:0] ram_wdata, ram_rdata;
    logic [CNT_W-1:0]  cnt_val;
    logic [PTR_W-1:0]  wp_cur;
    logic              full_cur;

    assign wr_hit     = bus_en & bus_we;
    assign rd_hit     = bus_en & ~bus_we;
    assign cap_on_wr  = wr_hit & (bus_addr == A_CTRL) & bus_wdata[0];
    assign cap_off_wr = wr_hit & (bus_addr == A_CTRL) & ~bus_wdata[0];
    assign flush_req  = wr_hit & (bus_addr == A_FCTRL) & bus_wdata[FC_FLUSH];
    assign cnt_wr     = wr_hit & (bus_addr == A_TCNT);
    assign wp_aligned = (regs_q.wp[FRAME_LOG-1:0] == '0);

    trace_ring_seq #(.CNT_W(CNT_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_on_wr    (cap_on_wr),
        .cap_off_wr   (cap_off_wr),
        .flush_req    (flush_req),
        .cnt_wr       (cnt_wr),
        .cnt_wdata    (bus_wdata[CNT_W-1:0]),
        .stop_trig_en (regs_q.stop_trig),
        .stop_flush_en(regs_q.stop_flush),
        .trc_valid    (trc_valid),
        .trc_trigger  (trc_trigger),
        .wp_aligned   (wp_aligned),
        .capturing    (capturing),
        .stopped      (stopped),
        .flush_busy   (flush_busy),
        .store_trace  (store_trace),
        .store_pad    (store_pad),
        .cnt_val      (cnt_val)
    );

    assign port_store = wr_hit & (bus_addr == A_WDATA) & stopped;
    assign ram_we     = store_trace | store_pad | port_store;

    always_comb begin
        if (store_trace) begin
            ram_wdata = trc_data;
        end else if (store_pad) begin
            ram_wdata = '0;
        end else begin
            ram_wdata = bus_wdata;
        end
    end

    trace_ring_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) ram_i (
        .clk  (clk),
        .we   (ram_we),
        .waddr(regs_q.wp),
        .wdata(ram_wdata),
        .raddr(regs_q.rp),
        .rdata(ram_rdata)
    );

    always_comb begin
        regs_d = regs_q;
        if (ram_we) begin
            regs_d.wp = regs_q.wp + PTR_W'(1);
            if (regs_q.wp == PTR_W'(DEPTH - 1)) begin
                regs_d.full = 1'b1;
            end
        end
        if (wr_hit && bus_addr == A_WPTR && stopped) begin
            regs_d.wp   = bus_wdata[PTR_W-1:0];
            regs_d.full = 1'b0;
        end
        if (wr_hit && bus_addr == A_RPTR) begin
            regs_d.rp = bus_wdata[PTR_W-1:0];
        end
        if (rd_hit && bus_addr == A_RDATA) begin
            regs_d.rp = regs_q.rp + PTR_W'(1);
        end
        if (wr_hit && bus_addr == A_FCTRL) begin
            regs_d.fmt_en     = bus_wdata[FC_EN];
            regs_d.stop_flush = bus_wdata[FC_STOPFL];
            regs_d.stop_trig  = bus_wdata[FC_STOPTRG];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            case (bus_addr)
                A_DEPTH:  bus_rdata = WORD_W'(DEPTH);
                A_STATUS: bus_rdata[0] = regs_q.full;
                A_RDATA:  bus_rdata = ram_rdata;
                A_RPTR:   bus_rdata[PTR_W-1:0] = regs_q.rp;
                A_WPTR:   bus_rdata[PTR_W-1:0] = regs_q.wp;
                A_TCNT:   bus_rdata[CNT_W-1:0] = cnt_val;
                A_CTRL:   bus_rdata[0] = capturing;
                A_FSTAT:  bus_rdata[FS_STOPPED] = stopped;
                A_FCTRL: begin
                    bus_rdata[FC_EN]      = regs_q.fmt_en;
                    bus_rdata[FC_FLUSH]   = flush_busy;
                    bus_rdata[FC_STOPFL]  = regs_q.stop_flush;
                    bus_rdata[FC_STOPTRG] = regs_q.stop_trig;
                end
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign wp_cur   = regs_q.wp;
    assign full_cur = regs_q.full;
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PTR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wbit0,
    input logic              trc_valid,
    input logic              ram_we,
    input logic [PTR_W-1:0]  wp_q,
    input logic              full_q,
    input logic              capturing,
    input logic              stopped,
    input logic              flush_busy,
    input logic              store_trace,
    input logic              store_pad
);
    logic ctrl_off_wr, wp_load;
    assign ctrl_off_wr = bus_en & bus_we & (bus_addr == A_CTRL) & ~bus_wbit0;
    assign wp_load     = bus_en & bus_we & (bus_addr == A_WPTR) & stopped;

    AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (wp_q == PTR_W'($past(wp_q) + PTR_W'(1)))); // R2
    AST_FULL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && wp_q == PTR_W'(DEPTH - 1)) |=> full_q); // R4
    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wp_load |=> !full_q); // R4
    AST_TRACE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        store_trace |-> (trc_valid && capturing)); // R5
    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_trace, store_pad})); // R9
    AST_STOP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(capturing) && !$past(ctrl_off_wr)) |-> (wp_q[FRAME_LOG-1:0] == '0)); // R9
    AST_FLUSH_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> capturing); // R10
endmodule

bind trace_ring_sink trace_ring_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wbit0  (bus_wdata[0]),
    .trc_valid  (trc_valid),
    .ram_we     (ram_we),
    .wp_q       (wp_cur),
    .full_q     (full_cur),
    .capturing  (capturing),
    .stopped    (stopped),
    .flush_busy (flush_busy),
    .store_trace(store_trace),
    .store_pad  (store_pad)
);

// File: tb/trace_ring_sink_tb_top.sv
`timescale 1ns/1ps
module trace_ring_sink_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trc_valid = 1'b0;
    logic [31:0] trc_data = '0;
    logic        trc_trigger = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trace_ring_sink #(.DEPTH(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic word(input logic [31:0] d, input logic trig);
        @(negedge clk);
        trc_valid = 1'b1; trc_data = d; trc_trigger = trig;
        @(posedge clk); #1;
        trc_valid = 1'b0; trc_trigger = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rd_chk(12'h020, 32'h0, "R1 ctrl");
        rd_chk(12'h300, 32'h2, "R1 fmt status");
        rd_chk(12'h00C, 32'h0, "R1 full");
        rd_chk(12'h018, 32'h0, "R1 wp");
        rd_chk(12'h014, 32'h0, "R1 rp");
        rd_chk(12'h01C, 32'h0, "R1 count");
        rd_chk(12'h004, 32'd16, "R1 depth");
    endtask

    task automatic t_port();
        wr(12'h024, 32'hA000_0000);
        wr(12'h024, 32'hA000_0001);
        wr(12'h024, 32'hA000_0002);
        rd_chk(12'h018, 32'd3, "R2 wp after port writes");
        wr(12'h014, 32'd0);
        for (int i = 0; i < 3; i++) rd_chk(12'h010, 32'hA000_0000 + i, "R3 readout");
        rd_chk(12'h014, 32'd3, "R3 rp advanced");
    endtask

    task automatic t_wrap();
        wr(12'h018, 32'd14);
        wr(12'h024, 32'hB000_0000);
        rd_chk(12'h00C, 32'h0, "R4 not full yet");
        wr(12'h024, 32'hB000_0001);
        rd_chk(12'h00C, 32'h1, "R4 full on wrap");
        rd_chk(12'h018, 32'd0, "R4 wp wrapped");
        wr(12'h014, 32'd15);
        rd_chk(12'h010, 32'hB000_0001, "R3 read last slot");
        rd_chk(12'h014, 32'd0, "R3 rp wrapped");
        wr(12'h018, 32'd4);
        rd_chk(12'h00C, 32'h0, "R4 full cleared by wp write");
    endtask

    task automatic t_capture();
        wr(12'h018, 32'd0);
        wr(12'h020, 32'd1);
        rd_chk(12'h300, 32'h0, "R5 running");
        rd_chk(12'h020, 32'h1, "R5 ctrl on");
        word(32'hC000_0000, 1'b0);
        word(32'hC000_0001, 1'b0);
        idle(2);
        word(32'hC000_0002, 1'b0);
        wr(12'h024, 32'hDEAD_BEEF);
        wr(12'h018, 32'd9);
        wr(12'h01C, 32'd7);
        rd_chk(12'h018, 32'd3, "R2 R13 wp unchanged during capture");
        rd_chk(12'h01C, 32'd0, "R13 count unchanged during capture");
        wr(12'h020, 32'd0);
        rd_chk(12'h020, 32'h0, "R5 ctrl off");
        rd_chk(12'h300, 32'h2, "R5 stopped");
        word(32'hEEEE_0000, 1'b0);
        rd_chk(12'h018, 32'd3, "R5 no store while stopped");
        wr(12'h014, 32'd0);
        for (int i = 0; i < 3; i++) rd_chk(12'h010, 32'hC000_0000 + i, "R5 captured data");
    endtask

    task automatic t_trig();
        wr(12'h304, 32'h2001);
        wr(12'h01C, 32'd3);
        wr(12'h018, 32'd0);
        wr(12'h020, 32'd1);
        word(32'hD000_0000, 1'b0);
        word(32'hD000_0001, 1'b0);
        word(32'hD000_0002, 1'b1);
        rd_chk(12'h01C, 32'd2, "R6 trigger word counted");
        word(32'hD000_0003, 1'b0);
        word(32'hD000_0004, 1'b0);
        idle(8);
        rd_chk(12'h018, 32'd8, "R9 wp padded to frame");
        rd_chk(12'h020, 32'h0, "R9 capture ended");
        rd_chk(12'h300, 32'h2, "R6 stopped");
        rd_chk(12'h01C, 32'd0, "R6 count exhausted");
        wr(12'h014, 32'd0);
        for (int i = 0; i < 5; i++) rd_chk(12'h010, 32'hD000_0000 + i, "R6 words kept");
        for (int i = 0; i < 3; i++) rd_chk(12'h010, 32'h0, "R9 zero pad");
        rd_chk(12'h304, 32'h2001, "R10 fmt bits readback");
    endtask

    task automatic t_trig_off();
        wr(12'h304, 32'h0001);
        wr(12'h01C, 32'd2);
        wr(12'h018, 32'd0);
        wr(12'h020, 32'd1);
        word(32'h1, 1'b1);
        word(32'h2, 1'b0);
        word(32'h3, 1'b0);
        word(32'h4, 1'b0);
        rd_chk(12'h018, 32'd4, "R8 all words stored");
        rd_chk(12'h020, 32'h1, "R8 still capturing");
        rd_chk(12'h01C, 32'd2, "R8 count untouched");
        wr(12'h020, 32'd0);
    endtask

    task automatic t_trig_zero();
        wr(12'h304, 32'h2000);
        wr(12'h01C, 32'd0);
        wr(12'h018, 32'd0);
        wr(12'h020, 32'd1);
        word(32'hF000_0000, 1'b0);
        word(32'hF000_0001, 1'b0);
        word(32'hF0F0_F0F0, 1'b1);
        idle(6);
        rd_chk(12'h018, 32'd4, "R7 padded without trigger word");
        rd_chk(12'h020, 32'h0, "R7 capture ended");
        wr(12'h014, 32'd2);
        rd_chk(12'h010, 32'h0, "R7 trigger word dropped");
    endtask

    task automatic t_flush_stop();
        wr(12'h304, 32'h1001);
        wr(12'h018, 32'd0);
        wr(12'h020, 32'd1);
        word(32'h5555_0000, 1'b0);
        wr(12'h304, 32'h1041);
        rd_chk(12'h304, 32'h1041, "R10 flush busy");
        idle(6);
        rd_chk(12'h304, 32'h1001, "R10 flush bit self-clears");
        rd_chk(12'h020, 32'h0, "R10 stop on flush");
        rd_chk(12'h018, 32'd4, "R10 flush padded");
    endtask

    task automatic t_flush_cont();
        wr(12'h304, 32'h0001);
        wr(12'h018, 32'd0);
        wr(12'h020, 32'd1);
        word(32'h6600_0000, 1'b0);
        word(32'h6600_0001, 1'b0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h304; bus_wdata = 32'h0041;
        trc_valid = 1'b1; trc_data = 32'h6600_0002;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0; trc_valid = 1'b0;
        idle(5);
        rd_chk(12'h304, 32'h0001, "R10 flush done");
        rd_chk(12'h020, 32'h1, "R10 capture continues");
        rd_chk(12'h018, 32'd4, "R12 wp after flush");
        word(32'h6600_0003, 1'b0);
        rd_chk(12'h018, 32'd5, "R10 capture resumed");
        wr(12'h020, 32'd0);
        wr(12'h014, 32'd2);
        rd_chk(12'h010, 32'h6600_0002, "R12 same-cycle word stored");
        rd_chk(12'h010, 32'h0, "R12 pad follows");
        rd_chk(12'h010, 32'h6600_0003, "R10 resumed word");
    endtask

    task automatic t_flush_idle();
        wr(12'h304, 32'h0041);
        rd_chk(12'h304, 32'h0001, "R11 idle flush completes");
        rd_chk(12'h300, 32'h2, "R11 still stopped");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_port();
        t_wrap();
        t_capture();
        t_trig();
        t_trig_off();
        t_trig_zero();
        t_flush_stop();
        t_flush_cont();
        t_flush_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule